// File: doc/BRIEF.md
# Dual-Mode Call/Return Stack Unit

This unit keeps the program counter and the hardware return stack of a core that fetches from either of two instruction memories. The first is a small local memory with 9-bit addresses. The second is a large shared memory with 16-bit addresses. The program counter is always 16 bits wide.

Each call pushes one frame onto the stack. The frame holds the return address, the Z and C flags supplied by the core, and the fetch mode of the caller. A return pops the frame and restores all of these at once. A call can therefore cross from shared to local code, or from local to shared code, and still land back in the caller's mode. Calls may nest in any mix of modes. A link-style return uses a 9-bit link address, except that the all-ones link value makes it behave as a stack return. The core can also capture the current PC into a holding register, for PC-relative table lookups.

All requests are sampled on the rising clock edge. Their effects are visible after that edge.

Top module: `callret_unit`

## Requirements
- R1: After a synchronous active-low reset the PC is 0, the mode is local (mode bit 0; 1 means shared), the stack is empty, the restored flags are 0 and all error pulses are low.
- R2: A call pushes the frame {return PC, Z in, C in, current mode} and loads the target in the target mode. The return PC is the current PC plus 1, taken modulo 512 in local mode. A local target is loaded as {7'b0, target[8:0]}.
- R3: A stack return pops the top frame and restores the PC, the mode and the Z and C flags from it.
- R4: A link return whose 9-bit link is not 0x1FF loads {7'b0, link}, selects local mode, and leaves the stack depth and the restored flags unchanged.
- R5: A link return whose link is 0x1FF behaves exactly as a stack return.
- R6: Calls nested in any mix of modes unwind in last-in, first-out order. Every level takes its mode, PC and flags from its own frame. The stack holds 256 frames.
- R7: A call while 256 frames are held leaves the stack, PC and mode unchanged, and pulses the overflow error for one cycle.
- R8: A return on an empty stack leaves the PC, mode and restored flags unchanged, and pulses the underflow error for one cycle.
- R9: A call together with any return in the same cycle performs only the return and pulses the conflict error for one cycle.
- R10: A capture request copies the PC held before that edge into the capture register. The capture register otherwise holds its value.
- R11: A jump loads the target in the target mode, with the same local masking as R2, and does not touch the stack. Priority is return, then call, then jump, then advance.
- R12: An advance request increments the PC. In local mode it wraps from 0x1FF to 0x000, and in shared mode it wraps modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Push a frame and go to the target |
| ret_req | input | 1 | Pop a frame and restore it |
| lret_req | input | 1 | Link return using link_addr |
| link_addr | input | 9 | Link address; 0x1FF means pop instead |
| jmp_req | input | 1 | Go to the target without using the stack |
| adv_req | input | 1 | Step the PC by one |
| cap_req | input | 1 | Copy the PC into cap_pc |
| tgt_addr | input | 16 | Call or jump target |
| tgt_mode | input | 1 | Target mode (0 local, 1 shared) |
| flag_z_in | input | 1 | Z flag to save on a call |
| flag_c_in | input | 1 | C flag to save on a call |
| pc | output | 16 | Current program counter |
| cur_mode | output | 1 | Current fetch mode |
| flag_z | output | 1 | Z flag restored by the last pop |
| flag_c | output | 1 | C flag restored by the last pop |
| depth | output | 9 | Frames held |
| stk_empty | output | 1 | No frames held |
| stk_full | output | 1 | 256 frames held |
| ovf_err | output | 1 | Overflow pulse |
| unf_err | output | 1 | Underflow pulse |
| cfl_err | output | 1 | Call/return conflict pulse |
| cap_pc | output | 16 | Captured PC |

## Verification
A call and a return can arrive in the same cycle. The bench drives both requests on one edge, once with a stack return and once with a link return. It then checks four things: the stack depth drops by exactly one, the PC and mode come from the popped frame, the pushed target has no effect, and the conflict pulse appears one cycle later. A call on a full stack is a second collision, between a push and the capacity limit. The bench provokes it after filling all 256 frames with mixed-mode calls. It judges the result by checking that the PC, mode and depth hold, and by watching the frames unwind afterwards.

// File: rtl/callret_pkg.sv
// Package: shared widths and the stack frame layout for the call/return unit.
// Assumes a 16-bit PC and a 9-bit local address space.
package callret_pkg;
    localparam int CR_PC_W  = 16;
    localparam int CR_LOC_W = 9;

    typedef enum logic {
        MODE_LOCAL  = 1'b0,
        MODE_SHARED = 1'b1
    } fetch_mode_e;

    typedef struct packed {
        logic [CR_PC_W-1:0] ret_pc;
        logic               z;
        logic               c;
        fetch_mode_e        mode;
    } frame_t;
endpackage

// File: rtl/callret_stack.sv
// Module: return-frame storage with an occupancy counter.
// Pushes are ignored when full and pops are ignored when empty.
// The top frame is read combinationally. Storage itself is not reset.
module callret_stack
    import callret_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  frame_t                     wr_frame,
    output frame_t                     top_frame,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    frame_t           mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [AW-1:0]    wr_idx;
    logic [AW-1:0]    top_idx;
    logic             do_push;
    logic             do_pop;

    assign full    = (cnt_q == CNT_MAX);
    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;
    assign do_push = push && !full && !pop;
    assign do_pop  = pop && !empty;
    assign wr_idx  = AW'(cnt_q);
    assign top_idx = AW'(cnt_q - CNT_W'(1));
    assign top_frame = mem[top_idx];

    // Track the number of frames held.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (do_pop)  cnt_q <= cnt_q - CNT_W'(1);
        else if (do_push) cnt_q <= cnt_q + CNT_W'(1);
    end

    // Write a pushed frame into the next free slot.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_idx] <= wr_frame;
    end

    // R7
    stk_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (cnt_q == CNT_MAX));
    // R8
    stk_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (cnt_q == '0));
    // R6
    stk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
endmodule

// File: rtl/callret_pcsel.sv
// Module: combinational selection of the next PC, mode and stack action.
// Priority: return (stack or sentinel link), link jump, call, jump, advance.
// Assumes that at most one frame moves per cycle.
module callret_pcsel
    import callret_pkg::*;
(
    input  logic [CR_PC_W-1:0]  pc_q,
    input  fetch_mode_e         mode_q,
    input  logic                call_req,
    input  logic                ret_req,
    input  logic                lret_req,
    input  logic [CR_LOC_W-1:0] link_addr,
    input  logic                jmp_req,
    input  logic                adv_req,
    input  logic [CR_PC_W-1:0]  tgt_addr,
    input  fetch_mode_e         tgt_mode,
    input  logic                flag_z_in,
    input  logic                flag_c_in,
    input  frame_t              top_frame,
    input  logic                stk_empty,
    input  logic                stk_full,
    output logic                do_push,
    output logic                do_pop,
    output frame_t              push_frame,
    output logic [CR_PC_W-1:0]  pc_nxt,
    output fetch_mode_e         mode_nxt,
    output logic                flags_ld,
    output logic                ovf_evt,
    output logic                unf_evt,
    output logic                cfl_evt
);
    localparam logic [CR_LOC_W-1:0] RESUME_SHARED = '1;

    logic               pop_path;
    logic               link_path;
    logic [CR_PC_W-1:0] step_pc;

    // Confine an address to the local space when the mode is local.
    function automatic logic [CR_PC_W-1:0] fit(input logic [CR_PC_W-1:0] a,
                                               input fetch_mode_e m);
        return (m == MODE_LOCAL) ? {{(CR_PC_W-CR_LOC_W){1'b0}}, a[CR_LOC_W-1:0]} : a;
    endfunction

    assign pop_path  = ret_req || (lret_req && (link_addr == RESUME_SHARED));
    assign link_path = lret_req && (link_addr != RESUME_SHARED);
    assign step_pc   = fit(CR_PC_W'(pc_q + CR_PC_W'(1)), mode_q);
    assign cfl_evt   = call_req && (ret_req || lret_req);

    // Choose the single action for this cycle and its result.
    always_comb begin
        do_push    = 1'b0;
        do_pop     = 1'b0;
        flags_ld   = 1'b0;
        ovf_evt    = 1'b0;
        unf_evt    = 1'b0;
        pc_nxt     = pc_q;
        mode_nxt   = mode_q;
        push_frame = '{ret_pc: step_pc, z: flag_z_in, c: flag_c_in, mode: mode_q};
        if (pop_path) begin
            if (stk_empty) begin
                unf_evt = 1'b1;
            end else begin
                do_pop   = 1'b1;
                flags_ld = 1'b1;
                pc_nxt   = top_frame.ret_pc;
                mode_nxt = top_frame.mode;
            end
        end else if (link_path) begin
            pc_nxt   = {{(CR_PC_W-CR_LOC_W){1'b0}}, link_addr};
            mode_nxt = MODE_LOCAL;
        end else if (call_req) begin
            if (stk_full) begin
                ovf_evt = 1'b1;
            end else begin
                do_push  = 1'b1;
                pc_nxt   = fit(tgt_addr, tgt_mode);
                mode_nxt = tgt_mode;
            end
        end else if (jmp_req) begin
            pc_nxt   = fit(tgt_addr, tgt_mode);
            mode_nxt = tgt_mode;
        end else if (adv_req) begin
            pc_nxt = step_pc;
        end
    end
endmodule

// File: rtl/callret_unit.sv
// Module: top of the dual-mode call/return unit. It holds the PC, the mode,
// the restored flags, the error pulses and the capture register, and
// instantiates the stack and the next-PC selector.
// Assumes requests are held stable around the rising clock edge.
module callret_unit
    import callret_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       call_req,
    input  logic                       ret_req,
    input  logic                       lret_req,
    input  logic [8:0]                 link_addr,
    input  logic                       jmp_req,
    input  logic                       adv_req,
    input  logic                       cap_req,
    input  logic [15:0]                tgt_addr,
    input  logic                       tgt_mode,
    input  logic                       flag_z_in,
    input  logic                       flag_c_in,
    output logic [15:0]                pc,
    output logic                       cur_mode,
    output logic                       flag_z,
    output logic                       flag_c,
    output logic [$clog2(DEPTH+1)-1:0] depth,
    output logic                       stk_empty,
    output logic                       stk_full,
    output logic                       ovf_err,
    output logic                       unf_err,
    output logic                       cfl_err,
    output logic [15:0]                cap_pc
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CR_PC_W-1:0] pc_q, pc_nxt;
    fetch_mode_e        mode_q, mode_nxt;
    frame_t             top_frame, push_frame;
    logic               do_push, do_pop, flags_ld;
    logic               ovf_evt, unf_evt, cfl_evt;
    logic               z_q, c_q;
    logic [CNT_W-1:0]   cnt;
    logic               full_w, empty_w;

    callret_stack #(.DEPTH(DEPTH)) i_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .wr_frame  (push_frame),
        .top_frame (top_frame),
        .count     (cnt),
        .full      (full_w),
        .empty     (empty_w)
    );

    callret_pcsel i_pcsel (
        .pc_q       (pc_q),
        .mode_q     (mode_q),
        .call_req   (call_req),
        .ret_req    (ret_req),
        .lret_req   (lret_req),
        .link_addr  (link_addr),
        .jmp_req    (jmp_req),
        .adv_req    (adv_req),
        .tgt_addr   (tgt_addr),
        .tgt_mode   (fetch_mode_e'(tgt_mode)),
        .flag_z_in  (flag_z_in),
        .flag_c_in  (flag_c_in),
        .top_frame  (top_frame),
        .stk_empty  (empty_w),
        .stk_full   (full_w),
        .do_push    (do_push),
        .do_pop     (do_pop),
        .push_frame (push_frame),
        .pc_nxt     (pc_nxt),
        .mode_nxt   (mode_nxt),
        .flags_ld   (flags_ld),
        .ovf_evt    (ovf_evt),
        .unf_evt    (unf_evt),
        .cfl_evt    (cfl_evt)
    );

    // Register the PC and the fetch mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mode_q <= MODE_LOCAL;
        end else begin
            pc_q   <= pc_nxt;
            mode_q <= mode_nxt;
        end
    end

    // Load the flags restored by a pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else if (flags_ld) begin
            z_q <= top_frame.z;
            c_q <= top_frame.c;
        end
    end

    // Turn each error event into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
            cfl_err <= 1'b0;
        end else begin
            ovf_err <= ovf_evt;
            unf_err <= unf_evt;
            cfl_err <= cfl_evt;
        end
    end

    // Capture the current PC for PC-relative lookups.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_pc <= '0;
        else if (cap_req) cap_pc <= pc_q;
    end

    assign pc        = pc_q;
    assign cur_mode  = mode_q;
    assign flag_z    = z_q;
    assign flag_c    = c_q;
    assign depth     = cnt;
    assign stk_empty = empty_w;
    assign stk_full  = full_w;

    // R9
    cfl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && (ret_req || lret_req)) |=> cfl_err);
    // R12
    local_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOCAL) |-> (pc_q[CR_PC_W-1:CR_LOC_W] == '0));
    // R8
    unf_hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && empty_w) |=> ($stable(pc_q) && unf_err));
    // R7
    ovf_hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req && !lret_req && full_w) |=> ($stable(pc_q) && ovf_err));
    // R6
    one_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({do_push, do_pop}) <= 1);
endmodule

// File: tb/test_callret_unit.sv
module test_callret_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 0, ret_req = 0, lret_req = 0, jmp_req = 0, adv_req = 0, cap_req = 0;
    logic [8:0]  link_addr = '0;
    logic [15:0] tgt_addr = '0;
    logic        tgt_mode = 0, flag_z_in = 0, flag_c_in = 0;
    logic [15:0] pc, cap_pc;
    logic        cur_mode, flag_z, flag_c, stk_empty, stk_full, ovf_err, unf_err, cfl_err;
    logic [8:0]  depth;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state derived from the requirements
    logic [15:0] m_pc;   logic m_mode, m_z, m_c, m_ovf, m_unf, m_cfl;
    logic [15:0] m_cap;  int m_sp;
    logic [15:0] s_pc [DEPTH];
    logic        s_z [DEPTH];
    logic        s_c [DEPTH];
    logic        s_m [DEPTH];

    callret_unit #(.DEPTH(DEPTH)) i_callret_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] fitm(input logic [15:0] a, input logic m);
        return m ? a : {7'b0, a[8:0]};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "pc", pc, m_pc);
        chk(req, "mode", cur_mode, m_mode);
        chk(req, "flag_z", flag_z, m_z);
        chk(req, "flag_c", flag_c, m_c);
        chk(req, "depth", depth, m_sp);
        chk(req, "empty", stk_empty, m_sp == 0);
        chk(req, "full", stk_full, m_sp == DEPTH);
        chk(req, "ovf", ovf_err, m_ovf);
        chk(req, "unf", unf_err, m_unf);
        chk(req, "cfl", cfl_err, m_cfl);
        chk(req, "cap", cap_pc, m_cap);
    endtask

    // one clock: drive at negedge, update model, sample after the edge
    task automatic cyc(input logic c, input logic r, input logic lr, input logic [8:0] lk,
                       input logic j, input logic a, input logic cp,
                       input logic [15:0] t, input logic tm, input logic z, input logic cc,
                       input string req);
        logic pop_p, link_p;
        logic [15:0] rpc;
        @(negedge clk);
        call_req = c; ret_req = r; lret_req = lr; link_addr = lk; jmp_req = j;
        adv_req = a; cap_req = cp; tgt_addr = t; tgt_mode = tm; flag_z_in = z; flag_c_in = cc;
        pop_p  = r || (lr && lk == 9'h1FF);
        link_p = lr && lk != 9'h1FF;
        rpc = fitm(m_pc + 16'd1, m_mode);
        m_ovf = 0; m_unf = 0; m_cfl = c && (r || lr);
        if (cp) m_cap = m_pc;
        if (pop_p) begin
            if (m_sp == 0) m_unf = 1;
            else begin
                m_sp--; m_pc = s_pc[m_sp]; m_mode = s_m[m_sp]; m_z = s_z[m_sp]; m_c = s_c[m_sp];
            end
        end else if (link_p) begin
            m_pc = {7'b0, lk}; m_mode = 0;
        end else if (c) begin
            if (m_sp == DEPTH) m_ovf = 1;
            else begin
                s_pc[m_sp] = rpc; s_m[m_sp] = m_mode; s_z[m_sp] = z; s_c[m_sp] = cc; m_sp++;
                m_pc = fitm(t, tm); m_mode = tm;
            end
        end else if (j) begin
            m_pc = fitm(t, tm); m_mode = tm;
        end else if (a) begin
            m_pc = rpc;
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        check_all(req);
    endtask

    task automatic idle(input string req);   cyc(0,0,0,0,0,0,0,0,0,0,0,req); endtask
    task automatic adv(input string req);    cyc(0,0,0,0,0,1,0,0,0,0,0,req); endtask
    task automatic jmp(input logic [15:0] t, input logic m, input string req);
        cyc(0,0,0,0,1,0,0,t,m,0,0,req); endtask
    task automatic call(input logic [15:0] t, input logic m, input logic z, input logic c, input string req);
        cyc(1,0,0,0,0,0,0,t,m,z,c,req); endtask
    task automatic ret(input string req);    cyc(0,1,0,0,0,0,0,0,0,0,0,req); endtask
    task automatic lret(input logic [8:0] l, input string req);
        cyc(0,0,1,l,0,0,0,0,0,0,0,req); endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_pc = 0; m_mode = 0; m_z = 0; m_c = 0; m_sp = 0; m_cap = 0;
        m_ovf = 0; m_unf = 0; m_cfl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #(CLK_PERIOD/4);
        check_all("R1 reset");

        // R12 local wrap and shared step
        jmp(16'h01FE, 0, "R11 local jump");
        adv("R12 local step");
        adv("R12 local wrap");
        jmp(16'hFFFF, 1, "R11 shared jump");
        adv("R12 shared wrap");
        jmp(16'h1234, 1, "R11 shared jump");
        // R2 call into local with masking, then cross back
        call(16'hABCD, 0, 1, 0, "R2 shared to local call");
        call(16'h8000, 1, 0, 1, "R2 local to shared call");
        lret(9'h1FF, "R5 sentinel link pops");
        lret(9'h055, "R4 link return local");
        ret("R3 stack return restores shared");
        ret("R8 underflow");
        idle("R8 pulse clears");
        // R10 capture
        cyc(0,0,0,0,0,1,1,0,0,0,0,"R10 capture with advance");
        idle("R10 capture held");
        // R9 conflicts
        call(16'h0010, 0, 1, 1, "R2 setup push");
        cyc(1,1,0,0,0,0,0,16'h7777,1,0,0,"R9 call with ret");
        call(16'h0020, 1, 0, 1, "R2 setup push");
        cyc(1,0,1,9'h1FF,0,0,0,16'h3333,0,1,1,"R9 call with sentinel link");
        cyc(1,0,1,9'h0AA,0,0,0,16'h3333,0,1,1,"R9 call with link jump");
        // R11 sweep local jumps over all local slots
        for (int i = 0; i < 512; i++)
            jmp(16'(i * 16'd131 + 16'hFE00), 0, "R11 local sweep");
        // R6 fill with mixed-mode nesting, then R7 overflow
        for (int i = 0; i < DEPTH; i++)
            call(16'(i * 16'd257 + 16'd3), i[0] ^ i[3], i[1], i[2], "R6 nested call");
        call(16'h4444, 1, 1, 1, "R7 overflow");
        call(16'h0004, 0, 0, 0, "R7 overflow repeat");
        idle("R7 pulse clears");
        for (int i = 0; i < DEPTH; i++) begin
            if (i % 3 == 0) lret(9'h1FF, "R5 unwind by sentinel");
            else            ret("R6 unwind");
        end
        ret("R8 underflow after unwind");
        lret(9'h1FF, "R8 sentinel underflow");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule